// File: doc/BRIEF.md
# Endpoint Base Address Register Bank

This block holds the six base address registers of an endpoint's type 0 configuration header. Each slot's shape is fixed when the design is elaborated: present or absent, memory or I/O space, 32-bit or 64-bit decoding, prefetchable or not, and a power-of-two aperture. Enumeration software sizes each slot by writing all ones and reading the value back. The address bits that fall inside the aperture are hardwired to zero, so the readback works as a size mask. The software then writes the assigned base into the bits that remain writable.

Configuration software reaches the bank through a dword-indexed port. The port has per-byte write enables and a read path that returns data one clock after the request, together with a valid strobe. Alongside this port, the block compares every incoming request address against the programmed bases. It reports which slot owns the address, gated by the memory-space and I/O-space enable inputs. A 64-bit memory slot at an even index uses the next index to hold the upper half of its base.

Top module: `bar_bank`

## Requirements
- R1: After a synchronous reset every writable base bit is zero. Each slot then reads back only its fixed type bits. With the defaults, slot 0 reads 0x0000000C, slot 3 reads 0x00000001, slot 5 reads 0x00000008, and slots 1, 2 and 4 read 0.
- R2: Bit 0 of each implemented slot is read-only and tells the space: 0 for memory, 1 for I/O. No write changes it.
- R3: On a memory slot, bits 2:1 are read-only and give the decoder width: 00 for 32-bit, 10 for 64-bit. Bit 3 is a read-only prefetchable flag set by a parameter.
- R4: An all-ones write followed by a read returns zeros in every address bit below the aperture size, with the type bits in place. With the defaults, the 256 KB slot 2 returns 0xFFFC0000 and the 1 MB slot 0 returns 0xFFF0000C.
- R5: A written base appears unchanged in the writable bits on every later read until the next write. Data bits below the aperture are dropped.
- R6: A slot whose size parameter is zero reads as all zeros and ignores writes. Indices 6 and 7 behave the same way.
- R7: The index that follows a 64-bit memory slot holds the upper 32 address bits and is writable in all 32 bits.
- R8: A write changes only the bytes whose enable bit is set. Byte enable bit b covers data bits 8b+7:8b.
- R9: A read request presented in one cycle gives rdata with rvalid high in the next cycle. rvalid stays low in any cycle that does not follow a request.
- R10: An I/O slot reads bit 1 as zero and takes address bits from bit 2 upward. With the defaults, the 256-byte slot 3 returns 0xFFFFFF01 after an all-ones write.
- R11: bar_hit bit k goes high for a memory slot only under three conditions: the memory enable is set, the request is a memory request, and the address with its in-aperture bits cleared equals the programmed base. A 32-bit slot also requires address bits 63:32 to be zero.
- R12: An I/O slot hits only for I/O requests while the I/O enable is set. With both enables clear, bar_hit is zero.
- R13: A 64-bit slot compares address bits 63:32 against the register at the following index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 3 | Dword register index, 0 to 5 valid |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | High one cycle after a read request |
| mem_en | input | 1 | Memory space decode enable |
| io_en | input | 1 | I/O space decode enable |
| req_addr | input | 64 | Request address to decode |
| req_io | input | 1 | Request targets I/O space |
| bar_hit | output | 6 | One bit per slot, high when that slot claims the request |

## Verification
Suppose a slot's stored base is wrong, for example a reset to the mask, a lost byte or a bit below the aperture that was kept. The error shows on the very next read of that slot, one clock after the request. It also shows at once in bar_hit, which is combinational. A wrong type or mask constant makes sizing reads differ from the expected mask in the first sizing pass. The bench therefore reads each slot back after reset, after sizing and after base programming. It then probes addresses on both sides of each aperture edge, so that an error in the state or the comparison shows up within a few cycles.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

    localparam int NUM_SLOTS = 6;
    localparam int IDX_W     = 3;
    localparam int LG_W      = 6;

    typedef enum logic [2:0] {
        ROLE_OFF,
        ROLE_M32,
        ROLE_M64LO,
        ROLE_M64HI,
        ROLE_IO
    } bar_role_e;

    typedef struct packed {
        logic [63:0] addr;
        logic        is_io;
        logic        mem_on;
        logic        io_on;
    } bar_req_t;

    function automatic bar_role_e role_of(input int idx,
                                          input logic [NUM_SLOTS*LG_W-1:0] lgv,
                                          input logic [NUM_SLOTS-1:0] iov,
                                          input logic [NUM_SLOTS-1:0] w64v);
        if (idx > 0 && ((idx - 1) % 2) == 0 && lgv[(idx-1)*LG_W +: LG_W] != 0 &&
            !iov[idx-1] && w64v[idx-1])
            return ROLE_M64HI;
        if (lgv[idx*LG_W +: LG_W] == 0)
            return ROLE_OFF;
        if (iov[idx])
            return ROLE_IO;
        if (w64v[idx] && (idx % 2) == 0 && idx < NUM_SLOTS - 1)
            return ROLE_M64LO;
        return ROLE_M32;
    endfunction

    function automatic logic [31:0] low_zero_mask(input int lg);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < 32; b++)
            if (b >= lg) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] wmask_of(input bar_role_e role, input logic [LG_W-1:0] lg);
        int eff;
        eff = int'(lg);
        if (eff > 31) eff = 31;
        case (role)
            ROLE_OFF:   return 32'h0;
            ROLE_M64HI: return 32'hFFFF_FFFF;
            ROLE_IO:    return low_zero_mask((eff < 2) ? 2 : eff);
            default:    return low_zero_mask((eff < 4) ? 4 : eff);
        endcase
    endfunction

    function automatic logic [31:0] roval_of(input bar_role_e role, input logic pref);
        case (role)
            ROLE_IO:    return 32'h1;
            ROLE_M32:   return {28'h0, pref, 3'b000};
            ROLE_M64LO: return {28'h0, pref, 3'b100};
            default:    return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_bank_pkg::*;
#(
    parameter logic [31:0] WMASK  = 32'h0,
    parameter logic [31:0] RO_VAL = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] q,
    output logic [31:0] rdval
);

    generate
        if (WMASK == 32'h0) begin : g_fixed
            logic unused_in;
            assign unused_in = ^{clk, rst, wr_en, be, wdata};
            assign q = 32'h0;
        end else begin : g_store
            logic [31:0] store_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    store_q <= '0;
                end else if (wr_en) begin
                    for (int b = 0; b < 4; b++)
                        if (be[b])
                            store_q[b*8 +: 8] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
                end
            end
            assign q = store_q;

            // R5: contents hold when no write is presented
            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(store_q));
            // R8: a write with no byte enabled leaves contents untouched
            assert_no_byte_R8: assert property (@(posedge clk) disable iff (rst)
                (wr_en && be == 4'b0000) |=> $stable(store_q));
        end
    endgenerate

    assign rdval = q | RO_VAL;

endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_bank_pkg::*;
#(
    parameter bar_role_e   ROLE  = ROLE_M32,
    parameter logic [31:0] WMASK = 32'hFFFF_F000
) (
    input  logic [31:0] lo_q,
    input  logic [31:0] hi_q,
    input  bar_req_t    req,
    output logic        hit
);

    localparam logic [63:0] CMP_MASK = {32'hFFFF_FFFF, WMASK};
    localparam logic        IS_IO    = (ROLE == ROLE_IO);
    localparam logic        IS_WIDE  = (ROLE == ROLE_M64LO);

    logic [63:0] base;
    logic        space_ok;

    always_comb begin
        base     = {(IS_WIDE ? hi_q : 32'h0), lo_q & WMASK};
        space_ok = IS_IO ? (req.is_io && req.io_on) : (!req.is_io && req.mem_on);
        hit      = space_ok && ((req.addr & CMP_MASK) == base);
    end

endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_bank_pkg::*;
#(
    parameter logic [NUM_SLOTS*LG_W-1:0] BAR_LOG2 = {6'd12, 6'd0, 6'd8, 6'd18, 6'd0, 6'd20},
    parameter logic [NUM_SLOTS-1:0]      BAR_IO   = 6'b001000,
    parameter logic [NUM_SLOTS-1:0]      BAR_W64  = 6'b000001,
    parameter logic [NUM_SLOTS-1:0]      BAR_PREF = 6'b100001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 cfg_rvalid,
    input  logic                 mem_en,
    input  logic                 io_en,
    input  logic [63:0]          req_addr,
    input  logic                 req_io,
    output logic [NUM_SLOTS-1:0] bar_hit
);

    logic [31:0] slot_q  [NUM_SLOTS];
    logic [31:0] slot_rd [NUM_SLOTS];
    bar_req_t    req;

    assign req = '{addr: req_addr, is_io: req_io, mem_on: mem_en, io_on: io_en};

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam bar_role_e   ROLE  = role_of(i, BAR_LOG2, BAR_IO, BAR_W64);
        localparam logic [31:0] WMASK = wmask_of(ROLE, BAR_LOG2[i*LG_W +: LG_W]);
        localparam logic [31:0] ROV   = roval_of(ROLE, BAR_PREF[i]);
        localparam int          NX    = (i < NUM_SLOTS - 1) ? i + 1 : i;

        bar_slot #(.WMASK(WMASK), .RO_VAL(ROV)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (cfg_wr && cfg_idx == IDX_W'(i)),
            .be    (cfg_be),
            .wdata (cfg_wdata),
            .q     (slot_q[i]),
            .rdval (slot_rd[i])
        );

        if (ROLE == ROLE_M32 || ROLE == ROLE_M64LO || ROLE == ROLE_IO) begin : g_dec
            bar_match #(.ROLE(ROLE), .WMASK(WMASK)) u_match (
                .lo_q (slot_q[i]),
                .hi_q (slot_q[NX]),
                .req  (req),
                .hit  (bar_hit[i])
            );
        end else begin : g_nodec
            assign bar_hit[i] = 1'b0;
        end
    end

    logic [31:0] rd_mux;
    always_comb begin
        rd_mux = 32'h0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (cfg_idx == IDX_W'(i)) rd_mux = slot_rd[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            if (cfg_rd) cfg_rdata <= rd_mux;
        end
    end

    // R9: one-cycle read latency with a single valid strobe
    assert_rd_lat_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_rd |=> cfg_rvalid);
    assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> !cfg_rvalid);
    // R6: indices past the last slot read as zero
    assert_oob_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_idx >= IDX_W'(NUM_SLOTS)) |=> cfg_rdata == 32'h0);
    // R12: no decode while both space enables are off
    assert_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (!mem_en && !io_en) |-> bar_hit == '0);

endmodule

// File: tb/sim_bar_bank.sv
`timescale 1ns/1ps
module sim_bar_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        mem_en = 1'b0, io_en = 1'b0, req_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic [5:0]  bar_hit;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    bar_bank u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .mem_en(mem_en), .io_en(io_en),
        .req_addr(req_addr), .req_io(req_io), .bar_hit(bar_hit)
    );

    // monitor: pops expected read data whenever the design presents a result
    always @(negedge clk) begin
        if (!rst && cfg_rvalid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected rvalid, actual %h expected none", cfg_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (cfg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", t, cfg_rdata, e);
                end
            end
        end
    end

    task automatic do_write(input logic [2:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] idx, input logic [31:0] e, input string t);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = idx;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        cfg_rd = 1'b0;
        @(negedge clk);
        n_tests++;
        if (cfg_rvalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: rvalid held, actual %b expected 0", cfg_rvalid);
        end
    endtask

    task automatic chk_hit(input logic [63:0] a, input logic io, input logic me,
                           input logic ie, input logic [5:0] e, input string t);
        @(negedge clk);
        req_addr = a; req_io = io; mem_en = me; io_en = ie;
        #1;
        n_tests++;
        if (bar_hit !== e) begin
            n_fail++;
            $display("FAIL %s: hit for %h actual %b expected %b", t, a, bar_hit, e);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (cfg_rvalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: rvalid in reset, actual %b expected 0", cfg_rvalid);
        end
        rst = 1'b0;

        // R1 R2 R3 R10: reset values show only type bits
        do_read(0, 32'h0000_000C, "R1 slot0 reset");
        do_read(1, 32'h0000_0000, "R1 slot1 reset");
        do_read(2, 32'h0000_0000, "R1 slot2 reset");
        do_read(3, 32'h0000_0001, "R2 slot3 io reset");
        do_read(4, 32'h0000_0000, "R6 slot4 reset");
        do_read(5, 32'h0000_0008, "R3 slot5 prefetch reset");
        do_read(6, 32'h0000_0000, "R6 index6 reset");

        // R4 R7 R10 R6: sizing
        for (int i = 0; i < 8; i++) do_write(3'(i), 4'hF, 32'hFFFF_FFFF);
        do_read(0, 32'hFFF0_000C, "R4 slot0 size");
        do_read(1, 32'hFFFF_FFFF, "R7 slot1 upper");
        do_read(2, 32'hFFFC_0000, "R4 slot2 size");
        do_read(3, 32'hFFFF_FF01, "R10 slot3 io size");
        do_read(4, 32'h0000_0000, "R6 disabled after write");
        do_read(5, 32'hFFFF_F008, "R4 slot5 size");
        do_read(7, 32'h0000_0000, "R6 index7 after write");

        // R5 R2: base programming
        do_write(0, 4'hF, 32'h4000_0000);
        do_write(1, 4'hF, 32'h0000_0001);
        do_write(2, 4'hF, 32'h1234_5678);
        do_read(2, 32'h1234_0000, "R5 low bits dropped");
        do_write(2, 4'hF, 32'h8004_0000);
        do_write(3, 4'hF, 32'h0000_1234);
        do_write(5, 4'hF, 32'h9000_0000);
        do_read(0, 32'h4000_000C, "R5 slot0 base");
        do_read(1, 32'h0000_0001, "R7 slot1 base");
        do_read(2, 32'h8004_0000, "R5 slot2 base");
        do_read(3, 32'h0000_1201, "R10 slot3 base");
        do_read(5, 32'h9000_0008, "R5 slot5 base");

        // R8: byte enables
        do_write(1, 4'b0010, 32'hAABB_CCDD);
        do_read(1, 32'h0000_CC01, "R8 single byte");
        do_write(2, 4'b0000, 32'hFFFF_FFFF);
        do_read(2, 32'h8004_0000, "R8 no byte");
        do_write(1, 4'hF, 32'h0000_0001);

        // R11 R12 R13: decode
        chk_hit(64'h1_4001_2345, 0, 1, 1, 6'b000001, "R13 wide hit");
        chk_hit(64'h0_4001_2345, 0, 1, 1, 6'b000000, "R13 wide upper mismatch");
        chk_hit(64'h0_8007_FFFF, 0, 1, 1, 6'b000100, "R11 top of aperture");
        chk_hit(64'h0_8008_0000, 0, 1, 1, 6'b000000, "R11 past aperture");
        chk_hit(64'h1_8004_0000, 0, 1, 1, 6'b000000, "R11 narrow above 4G");
        chk_hit(64'h0_8004_0010, 0, 0, 1, 6'b000000, "R11 mem disabled");
        chk_hit(64'h0_9000_0FFF, 0, 1, 1, 6'b100000, "R11 slot5 hit");
        chk_hit(64'h0_0000_12FF, 1, 1, 1, 6'b001000, "R12 io hit");
        chk_hit(64'h0_0000_12FF, 0, 1, 1, 6'b000000, "R12 mem request to io base");
        chk_hit(64'h0_0000_12FF, 1, 1, 0, 6'b000000, "R12 io disabled");
        chk_hit(64'h0_8004_0000, 0, 0, 0, 6'b000000, "R12 both off");

        repeat (4) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: reads unanswered, actual %0d expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule